// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the register file that a host sees on a simple Ethernet controller. The host uses an 8-bit data bus with a 4-bit offset. Offset 0 always reaches the command byte. Every other offset is decoded through a bank number, which is held in the top two bits of the command byte. The same offset can name one register on a write and a different one on a read.

The block keeps the following state:

- the receive-ring page bounds, exported as byte addresses;
- the boundary page;
- the transmit page and byte count;
- the remote-DMA start address and byte count;
- a data-configuration byte;
- the station MAC address, the 64-bit multicast filter and the current receive page;
- an interrupt status byte and an interrupt mask, which together drive a level interrupt.

Some command writes take effect in the cycle they land:

- A start with a remote read or write and a zero remote count flags DMA completion at once.
- A start with the transmit bit raises a one-cycle transmit request. The request carries the frame's byte address and length, and the transmit status is marked as successful.

Neighbouring receive and DMA logic reports its events through a set-only status input.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command byte reads 0x00, the interrupt status reads 0x80, the mask is 0x00, `irq` is low and `tx_req` is low.
- R2: Offset 0 reads and writes the command byte whatever the bank. The bank is command bits [7:6]: 0 is the operational bank and 1 is the address bank.
- R3: A bank-0 write with `bus_we` high at the clock edge stores its byte at that edge. Offset 1 is the ring start page and offset 2 the ring stop page; both are exported as page<<8. Offset 3 is the boundary, offset 4 the transmit page, offset 14 data configuration and offset 15 the interrupt mask.
- R4: The two-byte bank-0 values are split over pairs of offsets: transmit count at 5/6, remote address at 8/9, remote count at 10/11. The lower offset holds the low byte, and each write changes only its own byte.
- R5: In bank 1, offsets 1–6 hold MAC bytes 0–5 (byte k on `mac_addr[8k+7:8k]`), offset 7 holds the current page and offsets 8–15 hold filter bytes 0–7. All of them read back.
- R6: A bank-0 read returns the boundary at offset 3, the transmit status at offset 4 and the interrupt status at offset 7. Every other nonzero bank-0 offset, and every nonzero offset in banks 2 and 3, reads 0x00. Writes to banks 2 and 3 change nothing.
- R7: The status bits are RX=bit0, TX=bit1, RX_ERR=bit2, TX_ERR=bit3, OVER=bit4, COUNTERS=bit5, RDC=bit6, RESET=bit7.
  - A bank-0 write to offset 7 clears each status bit that is 1 in the written byte.
  - A 1 on `evt_set[k]` sets bit k at the next edge. A set wins over a clear in the same cycle.
- R8: `irq` is high exactly when (status AND mask) is nonzero. It follows any change of either register at the edge where that change lands.
- R9: A command write that has START (bit 1) and either remote read (bit 3) or remote write (bit 4) set sets RDC at that edge if the remote count is 0 at that moment.
- R10: A command write that has START and TRANSMIT (bit 2) set raises `tx_req` for exactly the following cycle, with `tx_addr` = transmit page<<8 and `tx_len` = the transmit count. At the same edge the transmit status becomes 0x01 and TX is set.
- R11: A command write without START issues no transmit request and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| evt_set | input | 8 | Per-bit status set requests from neighbours |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| tx_addr | output | 16 | Frame start byte address |
| tx_len | output | 16 | Frame length in bytes |
| ring_start_addr | output | 16 | Ring start, byte address |
| ring_stop_addr | output | 16 | Ring stop, byte address |
| boundary_page | output | 8 | Boundary page |
| rdma_addr | output | 16 | Remote DMA start address |
| rdma_count | output | 16 | Remote DMA byte count |
| data_cfg | output | 8 | Data configuration byte |
| mac_addr | output | 48 | Station address |
| mcast_mask | output | 64 | Multicast filter |
| cur_page | output | 8 | Current receive page |

## Verification
The bench builds the block with its default sizes: six MAC bytes and eight filter bytes. With those sizes the address bank uses every offset from 1 to 15, so the top filter slot at offset 15 and the current-page slot at offset 7 are both reached through the decode. The same build covers the read/write asymmetry at shared offsets, a status set colliding with a clear, a zero-count DMA start against a nonzero one, and transmit requests checked by a scoreboard queue.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned PTR_W  = 16;

  // command bit positions
  localparam int unsigned CMD_START  = 1;
  localparam int unsigned CMD_TRANS  = 2;
  localparam int unsigned CMD_RREAD  = 3;
  localparam int unsigned CMD_RWRITE = 4;

  // status bit positions
  localparam int unsigned ST_TX    = 1;
  localparam int unsigned ST_RDC   = 6;
  localparam logic [DATA_W-1:0] ST_RESET_VAL = 8'h80;

  // bank-0 offsets
  localparam logic [OFF_W-1:0] B0_START  = 4'd1;
  localparam logic [OFF_W-1:0] B0_STOP   = 4'd2;
  localparam logic [OFF_W-1:0] B0_BNDRY  = 4'd3;
  localparam logic [OFF_W-1:0] B0_TXPG   = 4'd4;
  localparam logic [OFF_W-1:0] B0_TCLO   = 4'd5;
  localparam logic [OFF_W-1:0] B0_TCHI   = 4'd6;
  localparam logic [OFF_W-1:0] B0_STAT   = 4'd7;
  localparam logic [OFF_W-1:0] B0_RALO   = 4'd8;
  localparam logic [OFF_W-1:0] B0_RAHI   = 4'd9;
  localparam logic [OFF_W-1:0] B0_RCLO   = 4'd10;
  localparam logic [OFF_W-1:0] B0_RCHI   = 4'd11;
  localparam logic [OFF_W-1:0] B0_CFG    = 4'd14;
  localparam logic [OFF_W-1:0] B0_MASK   = 4'd15;

  typedef struct packed {
    logic start_pg;
    logic stop_pg;
    logic bndry;
    logic tx_pg;
    logic tcnt_lo;
    logic tcnt_hi;
    logic stat_clr;
    logic radr_lo;
    logic radr_hi;
    logic rcnt_lo;
    logic rcnt_hi;
    logic cfg;
    logic mask;
  } b0_wr_t;
endpackage

// File: rtl/nic_addr_decode.sv
module nic_addr_decode
  import nic_pkg::*;
(
  input  logic             bus_we,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic [1:0]       bank,
  output logic             cmd_we,
  output b0_wr_t           b0_we,
  output logic             b1_we
);
  always_comb begin
    cmd_we = bus_we && (bus_addr == '0);
    b0_we  = '0;
    b1_we  = 1'b0;
    if (bus_we && (bus_addr != '0)) begin
      unique case (bank)
        2'd0: begin
          unique case (bus_addr)
            B0_START: b0_we.start_pg = 1'b1;
            B0_STOP:  b0_we.stop_pg  = 1'b1;
            B0_BNDRY: b0_we.bndry    = 1'b1;
            B0_TXPG:  b0_we.tx_pg    = 1'b1;
            B0_TCLO:  b0_we.tcnt_lo  = 1'b1;
            B0_TCHI:  b0_we.tcnt_hi  = 1'b1;
            B0_STAT:  b0_we.stat_clr = 1'b1;
            B0_RALO:  b0_we.radr_lo  = 1'b1;
            B0_RAHI:  b0_we.radr_hi  = 1'b1;
            B0_RCLO:  b0_we.rcnt_lo  = 1'b1;
            B0_RCHI:  b0_we.rcnt_hi  = 1'b1;
            B0_CFG:   b0_we.cfg      = 1'b1;
            B0_MASK:  b0_we.mask     = 1'b1;
            default:  ;
          endcase
        end
        2'd1:    b1_we = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nic_addr_bank.sv
module nic_addr_bank
  import nic_pkg::*;
#(
  parameter int unsigned MAC_BYTES   = 6,
  parameter int unsigned MCAST_BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [OFF_W-1:0]           off,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [MAC_BYTES*DATA_W-1:0]   mac_addr,
  output logic [MCAST_BYTES*DATA_W-1:0] mcast_mask,
  output logic [DATA_W-1:0]          cur_page
);
  localparam int unsigned MAC_BASE = 1;
  localparam int unsigned CUR_OFF  = MAC_BASE + MAC_BYTES;
  localparam int unsigned MC_BASE  = CUR_OFF + 1;
  localparam int unsigned LAST_OFF = MC_BASE + MCAST_BYTES - 1;

  initial begin
    if (LAST_OFF > (1 << OFF_W) - 1) $error("address bank does not fit the offset space");
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mac_addr   <= '0;
      mcast_mask <= '0;
      cur_page   <= '0;
    end else if (we) begin
      for (int i = 0; i < MAC_BYTES; i++)
        if (off == OFF_W'(MAC_BASE + i)) mac_addr[i*DATA_W +: DATA_W] <= wdata;
      for (int j = 0; j < MCAST_BYTES; j++)
        if (off == OFF_W'(MC_BASE + j)) mcast_mask[j*DATA_W +: DATA_W] <= wdata;
      if (off == OFF_W'(CUR_OFF)) cur_page <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < MAC_BYTES; i++)
      if (off == OFF_W'(MAC_BASE + i)) rdata = mac_addr[i*DATA_W +: DATA_W];
    for (int j = 0; j < MCAST_BYTES; j++)
      if (off == OFF_W'(MC_BASE + j)) rdata = mcast_mask[j*DATA_W +: DATA_W];
    if (off == OFF_W'(CUR_OFF)) rdata = cur_page;
  end
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_data,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] clr_vec;

  assign clr_vec = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= ST_RESET_VAL;
      mask_q <= '0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_data;
    end
  end

  assign irq = |(status & mask_q);
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_pkg::*;
#(
  parameter int unsigned MAC_BYTES   = 6,
  parameter int unsigned MCAST_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [3:0]                    bus_addr,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  input  logic [7:0]                    evt_set,
  output logic                          irq,
  output logic                          tx_req,
  output logic [15:0]                   tx_addr,
  output logic [15:0]                   tx_len,
  output logic [15:0]                   ring_start_addr,
  output logic [15:0]                   ring_stop_addr,
  output logic [7:0]                    boundary_page,
  output logic [15:0]                   rdma_addr,
  output logic [15:0]                   rdma_count,
  output logic [7:0]                    data_cfg,
  output logic [MAC_BYTES*8-1:0]        mac_addr,
  output logic [MCAST_BYTES*8-1:0]      mcast_mask,
  output logic [7:0]                    cur_page
);
  localparam int unsigned HALF = PTR_W / 2;

  logic [DATA_W-1:0] cmd_q, start_pg, stop_pg, tx_pg, tx_stat, isr_q, b1_rdata;
  logic [PTR_W-1:0]  tcnt_q;
  logic              cmd_we, b1_we, rdc_now, tx_now;
  b0_wr_t            b0_we;
  logic [DATA_W-1:0] set_vec;

  nic_addr_decode u_dec (
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .bank    (cmd_q[7:6]),
    .cmd_we  (cmd_we),
    .b0_we   (b0_we),
    .b1_we   (b1_we)
  );

  nic_addr_bank #(.MAC_BYTES(MAC_BYTES), .MCAST_BYTES(MCAST_BYTES)) u_bank1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (b1_we),
    .off       (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (b1_rdata),
    .mac_addr  (mac_addr),
    .mcast_mask(mcast_mask),
    .cur_page  (cur_page)
  );

  // immediate command actions
  assign rdc_now = cmd_we && bus_wdata[CMD_START] &&
                   (bus_wdata[CMD_RREAD] || bus_wdata[CMD_RWRITE]) &&
                   (rdma_count == '0);
  assign tx_now  = cmd_we && bus_wdata[CMD_START] && bus_wdata[CMD_TRANS];

  always_comb begin
    set_vec = evt_set;
    if (rdc_now) set_vec[ST_RDC] = 1'b1;
    if (tx_now)  set_vec[ST_TX]  = 1'b1;
  end

  nic_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_we   (b0_we.stat_clr),
    .clr_data (bus_wdata),
    .mask_we  (b0_we.mask),
    .mask_data(bus_wdata),
    .status   (isr_q),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q         <= '0;
      start_pg      <= '0;
      stop_pg       <= '0;
      boundary_page <= '0;
      tx_pg         <= '0;
      tcnt_q        <= '0;
      rdma_addr     <= '0;
      rdma_count    <= '0;
      data_cfg      <= '0;
      tx_stat       <= '0;
    end else begin
      if (cmd_we)         cmd_q         <= bus_wdata;
      if (b0_we.start_pg) start_pg      <= bus_wdata;
      if (b0_we.stop_pg)  stop_pg       <= bus_wdata;
      if (b0_we.bndry)    boundary_page <= bus_wdata;
      if (b0_we.tx_pg)    tx_pg         <= bus_wdata;
      if (b0_we.tcnt_lo)  tcnt_q[HALF-1:0]      <= bus_wdata;
      if (b0_we.tcnt_hi)  tcnt_q[PTR_W-1:HALF]  <= bus_wdata;
      if (b0_we.radr_lo)  rdma_addr[HALF-1:0]   <= bus_wdata;
      if (b0_we.radr_hi)  rdma_addr[PTR_W-1:HALF] <= bus_wdata;
      if (b0_we.rcnt_lo)  rdma_count[HALF-1:0]  <= bus_wdata;
      if (b0_we.rcnt_hi)  rdma_count[PTR_W-1:HALF] <= bus_wdata;
      if (b0_we.cfg)      data_cfg      <= bus_wdata;
      if (tx_now)         tx_stat       <= 8'h01;
    end
  end

  // transmit request, one cycle after the command write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_req  <= 1'b0;
      tx_addr <= '0;
      tx_len  <= '0;
    end else begin
      tx_req <= tx_now;
      if (tx_now) begin
        tx_addr <= {tx_pg, 8'h00};
        tx_len  <= tcnt_q;
      end
    end
  end

  assign ring_start_addr = {start_pg, 8'h00};
  assign ring_stop_addr  = {stop_pg, 8'h00};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      bus_rdata = cmd_q;
    end else begin
      unique case (cmd_q[7:6])
        2'd0: begin
          unique case (bus_addr)
            B0_BNDRY: bus_rdata = boundary_page;
            B0_TXPG:  bus_rdata = tx_stat;
            B0_STAT:  bus_rdata = isr_q;
            default:  bus_rdata = '0;
          endcase
        end
        2'd1:    bus_rdata = b1_rdata;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk #(
  parameter int unsigned MAC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       evt_set,
  input logic             tx_req,
  input logic [7:0]       isr,
  input logic [7:0]       cmd,
  input logic [15:0]      rdma_count,
  input logic [15:0]      ring_start_addr,
  input logic [MAC_W-1:0] mac_addr
);
  // R10
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(bus_we && bus_addr == 4'd0 && bus_wdata[1] && bus_wdata[2]));

  // R11
  no_start_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd0 && !bus_wdata[1]) |=> !tx_req);

  // R7
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((isr & $past(evt_set)) == $past(evt_set)));

  // R9
  zero_dma_rdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd0 && bus_wdata[1] && (bus_wdata[3] || bus_wdata[4])
     && rdma_count == 16'd0) |=> isr[6]);

  // R6
  dead_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != 4'd0 && cmd[7]) |=> ($stable(ring_start_addr) && $stable(mac_addr)));
endmodule

bind nic_regfile nic_regfile_chk #(.MAC_W(MAC_BYTES*8)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .evt_set        (evt_set),
  .tx_req         (tx_req),
  .isr            (isr_q),
  .cmd            (cmd_q),
  .rdma_count     (rdma_count),
  .ring_start_addr(ring_start_addr),
  .mac_addr       (mac_addr)
);

// File: tb/nic_regfile_tb.sv
module nic_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  evt_set = '0;
  logic        irq, tx_req;
  logic [15:0] tx_addr, tx_len, ring_start_addr, ring_stop_addr, rdma_addr, rdma_count;
  logic [7:0]  boundary_page, data_cfg, cur_page;
  logic [47:0] mac_addr;
  logic [63:0] mcast_mask;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct packed { logic [15:0] a; logic [15:0] l; } txe_t;
  txe_t exp_q[$];

  always #2 clk = ~clk;

  nic_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set), .irq(irq),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len),
    .ring_start_addr(ring_start_addr), .ring_stop_addr(ring_stop_addr),
    .boundary_page(boundary_page), .rdma_addr(rdma_addr), .rdma_count(rdma_count),
    .data_cfg(data_cfg), .mac_addr(mac_addr), .mcast_mask(mcast_mask), .cur_page(cur_page)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, 64'(bus_rdata), 64'(exp));
  endtask

  // scoreboard monitor for transmit requests (R10)
  always @(negedge clk) begin
    if (rst_n && tx_req) begin
      if (exp_q.size() == 0) begin
        chk("R10/R11 unexpected tx_req", 64'd1, 64'd0);
      end else begin
        txe_t e;
        e = exp_q.pop_front();
        chk("R10 tx_addr", 64'(tx_addr), 64'(e.a));
        chk("R10 tx_len", 64'(tx_len), 64'(e.l));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(4'd0, 8'h00, "R1 cmd");
    rd(4'd7, 8'h80, "R1 status");
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 tx_req", 64'(tx_req), 64'd0);
    // R2
    wr(4'd0, 8'h40);
    rd(4'd0, 8'h40, "R2 cmd bank1");
    // R5
    for (int i = 1; i <= 6; i++) wr(4'(i), 8'(8'h10 + i));
    wr(4'd7, 8'h4C);
    for (int j = 0; j < 8; j++) wr(4'(8 + j), 8'(8'hA0 + j));
    for (int i = 1; i <= 6; i++) rd(4'(i), 8'(8'h10 + i), "R5 mac read");
    rd(4'd7, 8'h4C, "R5 cur page read");
    rd(4'd15, 8'hA7, "R5 filter top");
    chk("R5 mac_addr", 64'(mac_addr), 64'h0000_1615_1413_1211);
    chk("R5 mcast", mcast_mask, 64'hA7A6_A5A4_A3A2_A1A0);
    chk("R5 cur_page", 64'(cur_page), 64'h4C);
    // R3
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h40); wr(4'd2, 8'h80); wr(4'd3, 8'h4C); wr(4'd14, 8'h49);
    chk("R3 ring start", 64'(ring_start_addr), 64'h4000);
    chk("R3 ring stop", 64'(ring_stop_addr), 64'h8000);
    chk("R3 data cfg", 64'(data_cfg), 64'h49);
    rd(4'd3, 8'h4C, "R3 boundary");
    // R4
    wr(4'd8, 8'h34); wr(4'd9, 8'h12);
    chk("R4 rdma addr", 64'(rdma_addr), 64'h1234);
    wr(4'd8, 8'h56);
    chk("R4 low byte only", 64'(rdma_addr), 64'h1256);
    wr(4'd10, 8'h00); wr(4'd11, 8'h00);
    chk("R4 rdma count", 64'(rdma_count), 64'h0);
    // R6
    rd(4'd1, 8'h00, "R6 write-only offset");
    rd(4'd5, 8'h00, "R6 unimplemented read");
    wr(4'd0, 8'h80);
    wr(4'd1, 8'h99);
    rd(4'd1, 8'h00, "R6 bank2 read");
    rd(4'd0, 8'h80, "R2 cmd bank2");
    wr(4'd0, 8'h40);
    rd(4'd1, 8'h11, "R6 bank2 write ignored mac");
    wr(4'd0, 8'h00);
    chk("R6 bank2 write ignored ring", 64'(ring_start_addr), 64'h4000);
    // R8 / R7
    wr(4'd15, 8'h80);
    chk("R8 irq on mask", 64'(irq), 64'd1);
    wr(4'd7, 8'h80);
    rd(4'd7, 8'h00, "R7 clear");
    chk("R8 irq off", 64'(irq), 64'd0);
    @(negedge clk); evt_set = 8'h05;
    @(negedge clk); evt_set = 8'h00;
    rd(4'd7, 8'h05, "R7 event set");
    chk("R8 masked out", 64'(irq), 64'd0);
    wr(4'd15, 8'h01);
    chk("R8 irq via mask", 64'(irq), 64'd1);
    wr(4'd7, 8'h01);
    rd(4'd7, 8'h04, "R7 partial clear");
    chk("R8 irq after clear", 64'(irq), 64'd0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd7; bus_wdata = 8'h04; evt_set = 8'h04;
    @(negedge clk);
    bus_we = 1'b0; evt_set = 8'h00;
    rd(4'd7, 8'h04, "R7 set wins");
    wr(4'd7, 8'h04);
    // R9
    wr(4'd0, 8'h0A);
    rd(4'd7, 8'h40, "R9 zero count read");
    wr(4'd7, 8'h40);
    wr(4'd10, 8'h01);
    wr(4'd0, 8'h12);
    rd(4'd7, 8'h00, "R9 nonzero count");
    wr(4'd10, 8'h00);
    // R11
    wr(4'd0, 8'h08);
    rd(4'd7, 8'h00, "R11 no start");
    // R10
    rd(4'd4, 8'h00, "R6 tx status idle");
    wr(4'd4, 8'h40); wr(4'd5, 8'hEA); wr(4'd6, 8'h05);
    exp_q.push_back('{a: 16'h4000, l: 16'h05EA});
    wr(4'd0, 8'h26);
    rd(4'd4, 8'h01, "R10 tx status");
    rd(4'd7, 8'h02, "R10 TX bit");
    wr(4'd0, 8'h04);
    wr(4'd4, 8'h7F); wr(4'd5, 8'h3C);
    exp_q.push_back('{a: 16'h7F00, l: 16'h053C});
    wr(4'd0, 8'h26);
    repeat (3) @(negedge clk);
    chk("R10 all requests seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule